// File: doc/BRIEF.md
# UART Address-Mark Mute Filter

This block follows a UART receive deserializer. It decides which received characters are handed to the host, using address-mark wakeup for buses with several receivers. For every completed character it removes the parity bit, as the frame format requires. It then checks whether the top data bit marks the character as an address. It also tracks whether this receiver is listening (awake) or muted.

An address character that carries a different node address mutes the receiver without telling the host. Software can force the same state with a one-cycle mute request. An address character that carries this node's address wakes the receiver, and that character is itself delivered as data. While the receiver is muted, ordinary data characters are dropped. Each delivered word raises a sticky valid flag, which a read acknowledge clears, and a one-cycle request strobe for an interrupt or DMA engine.

All outputs are registered. Each reacts in the clock cycle after the inputs that cause it.

Top module: `uart_mute_filter`

## Requirements
- R1: After reset the block is awake (`mute_o` = 0), `rx_valid_o` = 0 and `rx_req_o` = 0.
- R2: The frame select and the parity enable set the data width. `frame9_i`=0 with `parity_en_i`=1 gives 7 bits. `frame9_i`=0 with `parity_en_i`=0 gives 8 bits. `frame9_i`=1 with `parity_en_i`=1 gives 8 bits. `frame9_i`=1 with `parity_en_i`=0 gives 9 bits. The data field is `char_i[w-1:0]`, and the parity bit, when present, sits at `char_i[w]`. A delivered word holds the data field in `rx_data_o[w-1:0]`, with every bit above it zero.
- R3: A character is an address character when the data-field bit `char_i[w-1]` is 1. Its address is `char_i[w-2:0]`, which is 6, 7 or 8 bits wide for w = 7, 8 or 9. The address is compared with the same number of low bits of `node_addr_i`, and the higher bits of `node_addr_i` are ignored.
- R4: An address character that does not match sets `mute_o` in the next cycle. It raises neither `rx_valid_o` nor `rx_req_o`, and it leaves `rx_data_o` unchanged.
- R5: A `mute_req_i` pulse sets `mute_o` in the next cycle.
- R6: An address character that matches clears `mute_o` in the next cycle. In that same cycle it is delivered: `rx_valid_o` = 1, `rx_req_o` = 1, and `rx_data_o` holds the character without its parity bit.
- R7: While `mute_o` = 1, a data character (mark bit 0) is dropped: no valid flag, no request, and `rx_data_o` unchanged.
- R8: While `mute_o` = 0, data characters and matching address characters are delivered. Each delivery produces exactly one cycle of `rx_req_o`.
- R9: `rx_valid_o` stays set until `rd_ack_i` is asserted, and it is then clear in the next cycle. When a delivery and an acknowledge fall in the same cycle, the delivery wins.
- R10: A character completed in the same cycle as `mute_req_i` is judged by the mute state from before the request. In the next cycle `mute_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_i | input | 9 | Received character, parity bit included |
| char_done_i | input | 1 | One-cycle strobe: `char_i` is complete |
| frame9_i | input | 1 | 1 = nine-bit frame, 0 = eight-bit frame |
| parity_en_i | input | 1 | 1 = the frame carries a parity bit |
| node_addr_i | input | 8 | Programmed node address |
| mute_req_i | input | 1 | One-cycle software request to enter mute |
| rd_ack_i | input | 1 | Host has read the word; clears the valid flag |
| mute_o | output | 1 | Mute status |
| rx_valid_o | output | 1 | Receive-not-empty flag |
| rx_data_o | output | 9 | Delivered word, parity removed, zero-extended |
| rx_req_o | output | 1 | One-cycle interrupt/DMA request per delivery |

## Verification
A wrong mute bit shows up at the first data character after the fault. That character is then delivered when it should be dropped, or dropped when it should be delivered, and `rx_req_o` shows it in the very next cycle. `mute_o` exposes the mute bit directly one cycle after each address character or request. A wrong width choice mismatches addresses that differ only in the masked high bits, or leaves a parity bit in `rx_data_o`. The directed tests cover all four frame modes with such boundary patterns, and they cover the same-cycle collisions of a character with a request and of a delivery with an acknowledge.

// File: rtl/umf_pkg.sv
package umf_pkg;

    localparam int unsigned UMF_CHAR_W = 9;
    localparam int unsigned UMF_ADDR_W = UMF_CHAR_W - 1;

    // Decoded view of one received character
    typedef struct packed {
        logic                  is_addr;
        logic                  hit;
        logic [UMF_CHAR_W-1:0] data;
    } umf_dec_t;

    // Registered state of the filter
    typedef struct packed {
        logic                  mute;
        logic                  valid;
        logic                  req;
        logic [UMF_CHAR_W-1:0] data;
    } umf_state_t;

    // Mask with the lowest n bits set
    function automatic logic [UMF_CHAR_W-1:0] umf_low_mask(input int unsigned n);
        logic [UMF_CHAR_W-1:0] m;
        for (int unsigned i = 0; i < UMF_CHAR_W; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/umf_decode.sv
module umf_decode
    import umf_pkg::*;
#(
    parameter int unsigned CHAR_W = UMF_CHAR_W,
    parameter int unsigned ADDR_W = UMF_ADDR_W
) (
    input  logic [CHAR_W-1:0] char_i,
    input  logic              frame9_i,
    input  logic              parity_en_i,
    input  logic [ADDR_W-1:0] node_addr_i,
    output umf_dec_t          dec_o
);

    localparam int unsigned SHORT_DROP = 1;

    int unsigned           width;
    logic [CHAR_W-1:0]     data_mask;
    logic [CHAR_W-1:0]     addr_mask;
    logic [CHAR_W-1:0]     node_ext;
    logic                  mark;

    always_comb begin
        // data width from frame length and parity presence
        width = CHAR_W - (frame9_i ? 0 : SHORT_DROP) - (parity_en_i ? 1 : 0);
        data_mask = umf_low_mask(width);
        addr_mask = umf_low_mask(width - 1);
        node_ext  = CHAR_W'(node_addr_i);

        mark = 1'b0;
        for (int unsigned i = 0; i < CHAR_W; i++) begin
            if (i + 1 == width) begin
                mark = char_i[i];
            end
        end

        dec_o.data    = char_i & data_mask;
        dec_o.is_addr = mark;
        dec_o.hit     = ((char_i ^ node_ext) & addr_mask) == '0;
    end

endmodule

// File: rtl/umf_ctrl.sv
module umf_ctrl
    import umf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       char_done_i,
    input  umf_dec_t   dec_i,
    input  logic       mute_req_i,
    input  logic       rd_ack_i,
    output umf_state_t st_o
);

    umf_state_t st_d, st_q;
    logic       deliver;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;

        // the character is judged by the state before any request
        deliver = char_done_i && (dec_i.is_addr ? dec_i.hit : !st_q.mute);

        if (char_done_i && dec_i.is_addr) begin
            st_d.mute = !dec_i.hit;
        end
        if (mute_req_i) begin
            st_d.mute = 1'b1;
        end

        if (rd_ack_i) begin
            st_d.valid = 1'b0;
        end
        if (deliver) begin
            st_d.valid = 1'b1;
            st_d.req   = 1'b1;
            st_d.data  = dec_i.data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o = st_q;

    // R4
    miss_mutes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done_i && dec_i.is_addr && !dec_i.hit)
        |=> (st_q.mute && !st_q.req && $stable(st_q.data)));

    // R6
    hit_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done_i && dec_i.is_addr && dec_i.hit && !mute_req_i)
        |=> (!st_q.mute && st_q.valid && st_q.req));

    // R5
    req_mutes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_req_i |=> st_q.mute);

    // R7
    muted_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mute && char_done_i && !dec_i.is_addr)
        |=> (!st_q.req && $stable(st_q.data)));

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack_i && !char_done_i) |=> !st_q.valid);

    // R8
    req_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |-> st_q.valid);

endmodule

// File: rtl/uart_mute_filter.sv
module uart_mute_filter
    import umf_pkg::*;
#(
    parameter int unsigned CHAR_W = UMF_CHAR_W,
    parameter int unsigned ADDR_W = UMF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] char_i,
    input  logic              char_done_i,
    input  logic              frame9_i,
    input  logic              parity_en_i,
    input  logic [ADDR_W-1:0] node_addr_i,
    input  logic              mute_req_i,
    input  logic              rd_ack_i,
    output logic              mute_o,
    output logic              rx_valid_o,
    output logic [CHAR_W-1:0] rx_data_o,
    output logic              rx_req_o
);

    umf_dec_t   dec;
    umf_state_t st;

    umf_decode #(
        .CHAR_W (CHAR_W),
        .ADDR_W (ADDR_W)
    ) decode_i (
        .char_i      (char_i),
        .frame9_i    (frame9_i),
        .parity_en_i (parity_en_i),
        .node_addr_i (node_addr_i),
        .dec_o       (dec)
    );

    umf_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .char_done_i (char_done_i),
        .dec_i       (dec),
        .mute_req_i  (mute_req_i),
        .rd_ack_i    (rd_ack_i),
        .st_o        (st)
    );

    assign mute_o     = st.mute;
    assign rx_valid_o = st.valid;
    assign rx_data_o  = st.data;
    assign rx_req_o   = st.req;

endmodule

// File: tb/uart_mute_filter_tb_top.sv
module uart_mute_filter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] char_i = '0;
    logic       char_done_i = 1'b0;
    logic       frame9_i = 1'b0;
    logic       parity_en_i = 1'b0;
    logic [7:0] node_addr_i = 8'h05;
    logic       mute_req_i = 1'b0;
    logic       rd_ack_i = 1'b0;
    logic       mute_o;
    logic       rx_valid_o;
    logic [8:0] rx_data_o;
    logic       rx_req_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    uart_mute_filter dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .char_i      (char_i),
        .char_done_i (char_done_i),
        .frame9_i    (frame9_i),
        .parity_en_i (parity_en_i),
        .node_addr_i (node_addr_i),
        .mute_req_i  (mute_req_i),
        .rd_ack_i    (rd_ack_i),
        .mute_o      (mute_o),
        .rx_valid_o  (rx_valid_o),
        .rx_data_o   (rx_data_o),
        .rx_req_o    (rx_req_o)
    );

    task automatic check(input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    task automatic set_mode(input logic f9, input logic pe, input logic [7:0] node);
        frame9_i    = f9;
        parity_en_i = pe;
        node_addr_i = node;
    endtask

    // drive one character for one cycle; returns at the negedge after capture
    task automatic send(input logic [8:0] c);
        char_i      = c;
        char_done_i = 1'b1;
        @(negedge clk);
        char_done_i = 1'b0;
    endtask

    task automatic ack();
        rd_ack_i = 1'b1;
        @(negedge clk);
        rd_ack_i = 1'b0;
    endtask

    task automatic force_mute();
        mute_req_i = 1'b1;
        @(negedge clk);
        mute_req_i = 1'b0;
    endtask

    task automatic t_reset();
        check(mute_o, 0, "R1 mute after reset");
        check(rx_valid_o, 0, "R1 valid after reset");
        check(rx_req_o, 0, "R1 req after reset");
    endtask

    task automatic t_normal_data();
        set_mode(1'b0, 1'b0, 8'h05);
        send(9'h03C);
        check(rx_valid_o, 1, "R8 data valid");
        check(rx_data_o, 'h03C, "R8 data word");
        check(rx_req_o, 1, "R8 req raised");
        @(negedge clk);
        check(rx_req_o, 0, "R8 req one cycle");
        check(rx_valid_o, 1, "R9 valid held");
        ack();
        check(rx_valid_o, 0, "R9 ack clears");
    endtask

    task automatic t_miss_and_drop();
        set_mode(1'b0, 1'b0, 8'h05);
        send(9'h081);
        check(mute_o, 1, "R4 miss mutes");
        check(rx_valid_o, 0, "R4 no valid");
        check(rx_req_o, 0, "R4 no req");
        check(rx_data_o, 'h03C, "R4 data kept");
        send(9'h022);
        check(rx_valid_o, 0, "R7 muted data dropped");
        check(rx_req_o, 0, "R7 no req");
        check(rx_data_o, 'h03C, "R7 data kept");
        send(9'h085);
        check(mute_o, 0, "R6 hit wakes");
        check(rx_valid_o, 1, "R6 address delivered");
        check(rx_req_o, 1, "R6 req");
        check(rx_data_o, 'h085, "R6 address word");
        ack();
        send(9'h011);
        check(rx_data_o, 'h011, "R8 data after wake");
        check(rx_req_o, 1, "R8 req after wake");
        ack();
    endtask

    task automatic t_soft_mute();
        force_mute();
        check(mute_o, 1, "R5 request mutes");
        send(9'h012);
        check(rx_req_o, 0, "R7 drop after request");
        check(rx_data_o, 'h011, "R7 data kept after request");
    endtask

    task automatic t_seven_bit();
        // 7 data bits: parity at bit 7, mark bit 6, 6-bit address
        set_mode(1'b0, 1'b1, 8'h45);
        send(9'h0C5);
        check(mute_o, 0, "R3 6-bit address ignores node bit 6");
        check(rx_data_o, 'h045, "R2 parity stripped 7-bit");
        ack();
        send(9'h046);
        check(mute_o, 1, "R4 6-bit miss");
        check(rx_valid_o, 0, "R4 6-bit miss no valid");
    endtask

    task automatic t_nine_bit();
        set_mode(1'b1, 1'b0, 8'hA5);
        send(9'h1A4);
        check(mute_o, 1, "R3 9-bit miss on bit 0");
        send(9'h1A5);
        check(mute_o, 0, "R3 9-bit 8-bit address hit");
        check(rx_data_o, 'h1A5, "R2 9-bit word");
        ack();
    endtask

    task automatic t_nine_parity();
        // 8 data bits: parity at bit 8, mark bit 7, 7-bit address
        force_mute();
        set_mode(1'b1, 1'b1, 8'h85);
        send(9'h185);
        check(mute_o, 0, "R3 7-bit address ignores node bit 7");
        check(rx_data_o, 'h085, "R2 parity stripped 9-bit frame");
        ack();
        send(9'h112);
        check(rx_data_o, 'h012, "R2 data parity stripped");
        check(rx_valid_o, 1, "R8 data valid 8+p");
    endtask

    task automatic t_collisions();
        // delivery and ack together: delivery wins
        set_mode(1'b0, 1'b0, 8'h05);
        rd_ack_i = 1'b1;
        send(9'h033);
        rd_ack_i = 1'b0;
        check(rx_valid_o, 1, "R9 delivery beats ack");
        check(rx_data_o, 'h033, "R9 new word");
        ack();
        // request with a data character while awake
        mute_req_i = 1'b1;
        send(9'h044);
        mute_req_i = 1'b0;
        check(rx_data_o, 'h044, "R10 char judged awake");
        check(rx_req_o, 1, "R10 req");
        check(mute_o, 1, "R10 muted after");
        ack();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal_data();
        t_miss_and_drop();
        t_soft_mute();
        t_seven_bit();
        t_nine_bit();
        t_nine_parity();
        t_collisions();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule